// File: doc/BRIEF.md
# Addressable RGB LED Waveform Encoder

This block turns a stream of 24-bit colour words into the single-wire pulse train that a daisy chain of addressable RGB LEDs expects. It pulls words from the read side of a FIFO with a valid/ready handshake and shifts each one out as 24 symbols. A symbol is always a high phase followed by a low phase. The lengths of both phases depend on the symbol's value, and all four lengths are set in module clock cycles. A selector rearranges the three colour bytes of each word before they are sent, because different LED parts latch the colours in different orders.

Software sets the colour order, the four phase lengths, the reset gap and the pixel count, then pulses `start`. These settings are captured at that moment and held for the whole frame. The block sends exactly the requested number of pixels. If the FIFO runs dry partway through, the line waits low without losing a pixel. After the last pixel it holds the line low for the programmed gap, so the chain latches the new colours, and then it pulses `done` for one cycle.

Top module: `ledstrip_encoder`

## Requirements
- R1: After reset, and whenever no frame is in progress, `dout` is low and `busy`, `done` and `px_ready` are low.
- R2: A symbol of value 1 drives `dout` high for `t1_high` cycles and then low for `t1_low` cycles. A symbol of value 0 uses `t0_high` and `t0_low` instead. A programmed length of 0 behaves as 1 cycle. When the next pixel is already available, symbols follow one another with no extra low cycles, including across pixel boundaries.
- R3: In a colour word, red is in bits 23:16, green in 15:8 and blue in 7:0. The `order` input selects the byte sequence on the line: 0 = red, green, blue; 1 = red, blue, green; 2 = green, red, blue; 3 = green, blue, red; 4 = blue, red, green; 5 = blue, green, red. Codes 6 and 7 act like 2. Each byte is sent most significant bit first.
- R4: A frame takes exactly `len` words from the FIFO and emits exactly 24 × `len` high pulses. With `len` = 0 it emits no pulse, and `done` arrives `gap` cycles after the cycle in which `start` was sampled (a `gap` of 0 acting as 1).
- R5: After the low phase of the last symbol, `dout` stays low for a further `gap` cycles (0 acting as 1). In the next cycle, `done` is high for exactly one cycle.
- R6: If the FIFO has no word when the next pixel is due, `dout` stays low and the block waits. No pixel is skipped. The low phase before the delayed pixel is longer by exactly the number of cycles the FIFO was unavailable while `px_ready` was high. The wait does not shorten or lengthen the final reset gap.
- R7: A `start` pulse while `busy` is high is ignored, and changes to the configuration inputs during a frame have no effect on that frame.
- R8: `busy` goes high in the cycle after `start` is accepted. It stays high until the frame ends and is low in the cycle in which `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a frame (sampled only while idle) |
| order | input | 3 | Colour byte order code |
| len | input | LEN_W (13) | Number of pixels in the frame |
| t1_high | input | T1H_W (6) | High cycles of a 1 symbol |
| t1_low | input | T1L_W (5) | Low cycles of a 1 symbol |
| t0_high | input | T0H_W (5) | High cycles of a 0 symbol |
| t0_low | input | T0L_W (6) | Low cycles of a 0 symbol |
| gap | input | GAP_W (13) | Reset gap length in cycles |
| px_valid | input | 1 | FIFO holds a word |
| px_data | input | 24 | Colour word at the FIFO head |
| px_ready | output | 1 | Word is taken this cycle when `px_valid` is high |
| dout | output | 1 | Serial line to the LED chain |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse at the end of a frame |

## Verification
The hardest case to reach from the ports is an empty FIFO at exactly the moment a pixel boundary falls due. An ordinary delay on `px_valid` tends to expire while the previous pixel is still being shifted out, so it never actually stalls the line. The bench therefore withholds the chosen word only for a set number of cycles in which `px_ready` is high. This produces a precisely known stretch of the boundary low phase, which is then checked to the cycle. The bench also checks that the final reset gap is unchanged.

// File: rtl/ledstrip_pkg.sv
package ledstrip_pkg;

    localparam int CH_W  = 8;
    localparam int NCH   = 3;
    localparam int PIX_W = CH_W * NCH;
    localparam int ORD_W = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_HIGH,
        ST_LOW,
        ST_GAP
    } state_e;

    typedef struct packed {
        logic [CH_W-1:0] r;
        logic [CH_W-1:0] g;
        logic [CH_W-1:0] b;
    } rgb_t;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Arrange the colour bytes in line order; codes above 5 fall back to G,R,B.
    function automatic logic [PIX_W-1:0] reorder(input logic [ORD_W-1:0] ord,
                                                 input rgb_t p);
        logic [PIX_W-1:0] w;
        case (ord)
            3'd0:    w = {p.r, p.g, p.b};
            3'd1:    w = {p.r, p.b, p.g};
            3'd2:    w = {p.g, p.r, p.b};
            3'd3:    w = {p.g, p.b, p.r};
            3'd4:    w = {p.b, p.r, p.g};
            3'd5:    w = {p.b, p.g, p.r};
            default: w = {p.g, p.r, p.b};
        endcase
        return w;
    endfunction

endpackage

// File: rtl/ledstrip_phase_timer.sv
module ledstrip_phase_timer #(
    parameter int CW = 13
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expire
);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // A phase of length N ends in its N-th cycle; lengths 0 and 1 both last one cycle.
    assign expire = (cnt_q[CW-1:1] == '0);

    // R2
    cnt_mono_chk: assert property (@(posedge clk) disable iff (rst)
        !load |=> (cnt_q <= $past(cnt_q)));

endmodule

// File: rtl/ledstrip_bit_shifter.sv
module ledstrip_bit_shifter #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         shift,
    input  logic [W-1:0] din,
    output logic         cur_bit,
    output logic         next_bit,
    output logic         last_bit
);

    localparam int IW = $clog2(W);

    logic [W-1:0]  sh_q;
    logic [IW-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q  <= '0;
            idx_q <= '0;
        end else if (load) begin
            sh_q  <= din;
            idx_q <= IW'(W - 1);
        end else if (shift) begin
            sh_q  <= {sh_q[W-2:0], 1'b0};
            idx_q <= idx_q - 1'b1;
        end
    end

    assign cur_bit  = sh_q[W-1];
    assign next_bit = sh_q[W-2];
    assign last_bit = (idx_q == '0);

    // R3
    no_overshift_chk: assert property (@(posedge clk) disable iff (rst)
        shift |-> (idx_q != '0));

endmodule

// File: rtl/ledstrip_encoder.sv
module ledstrip_encoder
    import ledstrip_pkg::*;
#(
    parameter int LEN_W = 13,
    parameter int T1H_W = 6,
    parameter int T1L_W = 5,
    parameter int T0H_W = 5,
    parameter int T0L_W = 6,
    parameter int GAP_W = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [ORD_W-1:0] order,
    input  logic [LEN_W-1:0] len,
    input  logic [T1H_W-1:0] t1_high,
    input  logic [T1L_W-1:0] t1_low,
    input  logic [T0H_W-1:0] t0_high,
    input  logic [T0L_W-1:0] t0_low,
    input  logic [GAP_W-1:0] gap,
    input  logic             px_valid,
    input  logic [PIX_W-1:0] px_data,
    output logic             px_ready,
    output logic             dout,
    output logic             busy,
    output logic             done
);

    localparam int CW = max2(max2(max2(T1H_W, T1L_W), max2(T0H_W, T0L_W)), GAP_W);

    typedef struct packed {
        logic [ORD_W-1:0] ord;
        logic [T1H_W-1:0] t1h;
        logic [T1L_W-1:0] t1l;
        logic [T0H_W-1:0] t0h;
        logic [T0L_W-1:0] t0l;
        logic [GAP_W-1:0] gap;
    } cfg_t;

    cfg_t             cfg_q, cfg_in;
    state_e           st_q, st_d;
    logic [LEN_W-1:0] left_q;
    logic             done_q;

    logic             expire, cur_bit, next_bit, last_bit;
    logic             t_load, sh_load, sh_shift, take, more;
    logic [CW-1:0]    t_val;
    logic [PIX_W-1:0] fresh;

    assign cfg_in = '{ord: order, t1h: t1_high, t1l: t1_low,
                      t0h: t0_high, t0l: t0_low, gap: gap};

    assign fresh = reorder(cfg_q.ord, rgb_t'(px_data));
    assign more  = (left_q != '0);

    function automatic logic [CW-1:0] high_of(input logic b, input cfg_t c);
        return b ? CW'(c.t1h) : CW'(c.t0h);
    endfunction

    function automatic logic [CW-1:0] low_of(input logic b, input cfg_t c);
        return b ? CW'(c.t1l) : CW'(c.t0l);
    endfunction

    always_comb begin
        st_d     = st_q;
        t_load   = 1'b0;
        t_val    = '0;
        sh_load  = 1'b0;
        sh_shift = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (start) begin
                    if (len == '0) begin
                        t_load = 1'b1;
                        t_val  = CW'(gap);
                        st_d   = ST_GAP;
                    end else begin
                        st_d   = ST_FETCH;
                    end
                end
            end
            ST_FETCH: begin
                if (px_valid) begin
                    sh_load = 1'b1;
                    t_load  = 1'b1;
                    t_val   = high_of(fresh[PIX_W-1], cfg_q);
                    st_d    = ST_HIGH;
                end
            end
            ST_HIGH: begin
                if (expire) begin
                    t_load = 1'b1;
                    t_val  = low_of(cur_bit, cfg_q);
                    st_d   = ST_LOW;
                end
            end
            ST_LOW: begin
                if (expire) begin
                    if (!last_bit) begin
                        sh_shift = 1'b1;
                        t_load   = 1'b1;
                        t_val    = high_of(next_bit, cfg_q);
                        st_d     = ST_HIGH;
                    end else if (more) begin
                        if (px_valid) begin
                            sh_load = 1'b1;
                            t_load  = 1'b1;
                            t_val   = high_of(fresh[PIX_W-1], cfg_q);
                            st_d    = ST_HIGH;
                        end else begin
                            st_d    = ST_FETCH;
                        end
                    end else begin
                        t_load = 1'b1;
                        t_val  = CW'(cfg_q.gap);
                        st_d   = ST_GAP;
                    end
                end
            end
            ST_GAP: begin
                if (expire) begin
                    st_d = ST_IDLE;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    assign px_ready = (st_q == ST_FETCH) ||
                      ((st_q == ST_LOW) && expire && last_bit && more);
    assign take     = px_ready && px_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            cfg_q  <= '0;
            left_q <= '0;
            done_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            done_q <= (st_q == ST_GAP) && expire;
            if ((st_q == ST_IDLE) && start) begin
                cfg_q  <= cfg_in;
                left_q <= len;
            end else if (take) begin
                left_q <= left_q - 1'b1;
            end
        end
    end

    ledstrip_phase_timer #(.CW(CW)) i_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (t_load),
        .load_val (t_val),
        .expire   (expire)
    );

    ledstrip_bit_shifter #(.W(PIX_W)) i_shifter (
        .clk      (clk),
        .rst      (rst),
        .load     (sh_load),
        .shift    (sh_shift),
        .din      (fresh),
        .cur_bit  (cur_bit),
        .next_bit (next_bit),
        .last_bit (last_bit)
    );

    assign dout = (st_q == ST_HIGH);
    assign busy = (st_q != ST_IDLE);
    assign done = done_q;

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!dout && !px_ready));

    // R5
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R7
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(cfg_q));

    // R4
    take_bound_chk: assert property (@(posedge clk) disable iff (rst)
        take |-> more);

endmodule

// File: tb/test_ledstrip_encoder.sv
module test_ledstrip_encoder;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [2:0]  order = '0;
    logic [12:0] len = '0;
    logic [5:0]  t1_high = '0;
    logic [4:0]  t1_low = '0;
    logic [4:0]  t0_high = '0;
    logic [5:0]  t0_low = '0;
    logic [12:0] gap = '0;
    logic        px_valid;
    logic [23:0] px_data;
    logic        px_ready, dout, busy, done;

    int checks = 0;
    int errors = 0;

    // FIFO model
    logic [23:0] fifo_px [16];
    int   nfill = 0, st_at = -1, st_len = 0;
    int   rd = 0, hold = 0;
    logic fclr = 1'b0;

    assign px_valid = (rd < nfill) && !((rd == st_at) && (hold < st_len));
    assign px_data  = fifo_px[rd[3:0]];

    always @(posedge clk) begin
        if (fclr) begin
            rd   <= 0;
            hold <= 0;
        end else begin
            if (px_valid && px_ready) rd <= rd + 1;
            if ((rd == st_at) && px_ready && (hold < st_len)) hold <= hold + 1;
        end
    end

    // Line monitor, samples at the falling edge
    int   hi_len [128];
    int   lo_len [128];
    int   nhi = 0, run = 0, done_cnt = 0, takes = 0, final_low = -1;
    logic prev = 1'b0, busy_at_done = 1'b0, mclr = 1'b0;

    always @(negedge clk) begin
        if (mclr) begin
            nhi = 0; run = 0; prev = 1'b0; done_cnt = 0; takes = 0;
            final_low = -1; busy_at_done = 1'b0;
        end else begin
            if (px_valid && px_ready) takes++;
            if (done) begin
                done_cnt++;
                final_low    = prev ? 0 : run;
                busy_at_done = busy;
                run = 0; prev = 1'b0;
            end else if (dout) begin
                if (!prev) begin
                    if (nhi > 0 && nhi <= 128) lo_len[nhi-1] = run;
                    run = 1;
                end else begin
                    run++;
                end
                prev = 1'b1;
            end else begin
                if (prev) begin
                    if (nhi < 128) hi_len[nhi] = run;
                    nhi++;
                    run = 1;
                end else begin
                    run++;
                end
                prev = 1'b0;
            end
        end
    end

    ledstrip_encoder i_ledstrip_encoder (
        .clk(clk), .rst(rst), .start(start), .order(order), .len(len),
        .t1_high(t1_high), .t1_low(t1_low), .t0_high(t0_high), .t0_low(t0_low),
        .gap(gap), .px_valid(px_valid), .px_data(px_data), .px_ready(px_ready),
        .dout(dout), .busy(busy), .done(done)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int eff(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    function automatic logic [23:0] line_word(input int ord, input logic [23:0] p);
        logic [7:0] r, g, b;
        r = p[23:16]; g = p[15:8]; b = p[7:0];
        case (ord)
            0: return {r, g, b};
            1: return {r, b, g};
            3: return {g, b, r};
            4: return {b, r, g};
            5: return {b, g, r};
            default: return {g, r, b};
        endcase
    endfunction

    task automatic run_frame(input int ord, input int n, input int a1h, input int a1l,
                             input int a0h, input int a0l, input int g,
                             input int stall_at, input int stall_len, input bit poke,
                             input int seed);
        int cyc;
        int nbits;
        @(posedge clk); #2;
        fclr = 1'b1;
        for (int p = 0; p < 16; p++)
            fifo_px[p] = 24'((p + 1) * 24'h3b5a17 ^ (seed * 24'h91c4e3));
        nfill  = n;
        st_at  = stall_at;
        st_len = stall_len;
        @(posedge clk); #2;
        fclr    = 1'b0;
        order   = 3'(ord);
        len     = 13'(n);
        t1_high = 6'(a1h);
        t1_low  = 5'(a1l);
        t0_high = 5'(a0h);
        t0_low  = 6'(a0l);
        gap     = 13'(g);
        start   = 1'b1;
        mclr    = 1'b1;
        @(posedge clk); #2;
        start = 1'b0;
        mclr  = 1'b0;
        cyc = 0;
        forever begin
            @(negedge clk);
            if (cyc == 0) chk(busy == 1'b1, "R8 busy after start", int'(busy), 1);
            if (done) break;
            if (poke && cyc == 20) begin
                start = 1'b1; t1_high = 6'd9; t0_high = 5'd7; t1_low = 5'd9;
                t0_low = 6'd9; gap = 13'd40; order = 3'd5;
            end else begin
                start = 1'b0;
            end
            cyc++;
        end
        start = 1'b0;
        repeat (8) @(posedge clk);
        #2;
        nbits = 24 * n;
        chk(nhi == nbits, "R4 pulse count", nhi, nbits);
        chk(takes == n, "R4 words taken", takes, n);
        chk(done_cnt == 1, poke ? "R7 single done" : "R5 single done", done_cnt, 1);
        chk(busy_at_done == 1'b0, "R8 idle at done", int'(busy_at_done), 0);
        if (n == 0) begin
            chk(cyc == eff(g), "R4 empty frame gap", cyc, eff(g));
        end else if (nhi == nbits) begin
            for (int p = 0; p < n; p++) begin
                logic [23:0] w;
                w = line_word(ord, fifo_px[p]);
                for (int k = 0; k < 24; k++) begin
                    int  i;
                    bit  v;
                    int  eh, el, ex;
                    i  = p * 24 + k;
                    v  = w[23-k];
                    eh = v ? eff(a1h) : eff(a0h);
                    el = v ? eff(a1l) : eff(a0l);
                    chk(hi_len[i] == eh, "R3 symbol high", hi_len[i], eh);
                    if (i < nbits - 1) begin
                        ex = (stall_at > 0 && i == 24 * stall_at - 1) ? stall_len : 0;
                        chk(lo_len[i] == el + ex, (ex != 0) ? "R6 stall stretch" : "R2 symbol low",
                            lo_len[i], el + ex);
                    end else begin
                        chk(final_low == el + eff(g), "R5 reset gap", final_low, el + eff(g));
                    end
                end
            end
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(dout == 1'b0, "R1 dout idle", int'(dout), 0);
        chk(busy == 1'b0, "R1 busy idle", int'(busy), 0);
        chk(done == 1'b0, "R1 done idle", int'(done), 0);
        chk(px_ready == 1'b0, "R1 ready idle", int'(px_ready), 0);

        // R3: every order code, distinct high lengths for 1 and 0
        for (int o = 0; o < 8; o++)
            run_frame(o, 2, 3, 2, 1, 4, 5, -1, 0, 1'b0, o);

        // R2: timing sweep including zero lengths
        run_frame(2, 1, 0, 0, 0, 0, 0, -1, 0, 1'b0, 11);
        run_frame(0, 3, 5, 1, 2, 6, 3, -1, 0, 1'b0, 12);
        run_frame(4, 2, 1, 3, 4, 1, 7, -1, 0, 1'b0, 13);
        run_frame(1, 1, 63, 31, 31, 63, 2, -1, 0, 1'b0, 14);

        // R4: empty frame, gap only
        run_frame(2, 0, 3, 2, 1, 4, 6, -1, 0, 1'b0, 15);
        run_frame(2, 0, 3, 2, 1, 4, 0, -1, 0, 1'b0, 16);

        // R6: FIFO empty at pixel boundaries
        run_frame(3, 3, 2, 3, 1, 2, 4, 1, 5, 1'b0, 17);
        run_frame(5, 2, 2, 3, 1, 2, 4, 1, 1, 1'b0, 18);

        // R7: start and configuration changes during a frame are ignored
        run_frame(2, 2, 3, 2, 1, 4, 5, -1, 0, 1'b1, 19);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule